// File: doc/BRIEF.md
# Post-Modify Address Generator with Modulo Wrap

This unit produces data-memory addresses for a signal processing core. It keeps four 16-bit pointer registers, a pair of circular-buffer limit registers (ring start and ring end), two signed step registers and an 11-bit page register for direct addressing. On each request it registers an address. For an indirect request it outputs the selected pointer and then steps that pointer by a fixed or user-defined amount. For a direct request it joins the page register to a 5-bit field that comes with the request, and it also passes along which of 16 data registers is the partner of the move.

When the ring start is non-zero and a pointer that sits on the ring end is stepped forward, the pointer reloads the ring start. This gives circular buffers with no extra instructions. Every registered address is also decoded into one enable per on-chip 1K-word RAM bank, or into one of three external segments (high external RAM, low external RAM, IO). A single fixed address inside the IO segment drives its own select line.

All registers are loaded through a single write port. Addresses are due one clock after the request.

Top module: `agu_top`

## Requirements
- R1: After reset all pointer, ring, step and page registers read as zero, `addrValid` is 0 and every enable output is 0.
- R2: A request with `reqValid`=1 gives `addrValid`=1 in the next cycle. A cycle without a request gives `addrValid`=0 in the next cycle. For an indirect request (`reqMode`[1]=0), `addr` equals the value that pointer `ptrSel` held before the request edge.
- R3: On an indirect request the selected pointer is updated after its address is taken. `incSel` codes: 0 no change, 1 +1, 2 -1, 4 add the step register J, 5 add the step register K (two's complement, modulo 2^16), 6 and 7 no change.
- R4: `incSel`=3 adds +2 only in compound mode (`reqMode`=2'b01). In plain mode (`reqMode`=2'b00) it leaves the pointer unchanged.
- R5: When the ring start is non-zero and the pointer equals the ring end, a forward step (codes 1, 3 in compound mode, 4, 5) loads the ring start in place of the sum. A -1 step never wraps.
- R6: When the ring start is zero, no wrap happens and every step is plain linear arithmetic.
- R7: A direct request (`reqMode`[1]=1) gives `addr` = {page[10:0], `dirField`[4:0]} and changes no pointer.
- R8: `moveReg` shows `dirReg` from a direct request and 0 after an indirect request.
- R9: When `addrValid`=1 and `addr` < 4096, exactly one `bankEn` bit is set: bit `addr`[11:10]. At other addresses `bankEn` is 0.
- R10: Above the banks, addresses 0x4000 to 0x4FFF raise `ioEn`, addresses with bit 15 set raise `eramHiEn`, and all other addresses raise `eramLoEn`. Exactly one enable is high when `addrValid`=1, and none is high when `addrValid`=0.
- R11: `ioSelEn` is 1 exactly when `addrValid`=1 and `addr`=0x4010.
- R12: `wrSel` codes: 0 to 3 select a pointer, 4 the ring start, 5 the ring end, 6 J, 7 K, 8 the page (from `wrData`[10:0]). Codes 9 to 15 are ignored. When a write and a step target the same pointer in the same cycle, the written value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 4 | Register select for write |
| wrData | input | 16 | Write data |
| reqValid | input | 1 | Address request |
| reqMode | input | 2 | 00 plain indirect, 01 compound indirect, 1x direct |
| ptrSel | input | 2 | Pointer used by indirect request |
| incSel | input | 3 | Post-modify step code |
| dirField | input | 5 | Low address bits for direct request |
| dirReg | input | 4 | Move-partner register for direct request |
| addrValid | output | 1 | Registered address is valid |
| addr | output | 16 | Registered address |
| moveReg | output | 4 | Move-partner register of last direct request |
| bankEn | output | 4 | On-chip bank enables |
| eramHiEn | output | 1 | High external RAM enable |
| eramLoEn | output | 1 | Low external RAM enable |
| ioEn | output | 1 | IO segment enable |
| ioSelEn | output | 1 | Single-address IO select |

## Verification
The address, `addrValid` and `moveReg` are due on the first rising edge after the request. The decoded enables follow that same register through logic only, so they are due in the same cycle. A pointer update or a register write at an edge affects only requests issued after that edge. The bench drives inputs on the falling edge. It computes the expected outputs from a model of the registers as they were before the edge, then advances the model, and samples just after the next rising edge. In this way every request is matched to the one cycle its result belongs to.

// File: rtl/agu_pkg.sv
package agu_pkg;
  localparam int NPTR = 4;
  localparam int PTRW = $clog2(NPTR);

  typedef enum logic [2:0] {
    STEP_NONE = 3'd0,
    STEP_P1   = 3'd1,
    STEP_M1   = 3'd2,
    STEP_P2   = 3'd3,
    STEP_J    = 3'd4,
    STEP_K    = 3'd5
  } step_e;

  typedef struct packed {
    logic            capture;
    logic            direct;
    logic            stepEn;
    step_e           step;
    logic [PTRW-1:0] ptrIdx;
  } strobe_t;
endpackage

// File: rtl/agu_ctrl.sv
module agu_ctrl
  import agu_pkg::*;
(
  input  logic            reqValid,
  input  logic [1:0]      reqMode,
  input  logic [PTRW-1:0] ptrSel,
  input  logic [2:0]      incSel,
  output strobe_t         st
);
  step_e stepSel;

  always_comb begin
    stepSel = STEP_NONE;
    if (!reqMode[1]) begin
      unique case (incSel)
        3'd1:    stepSel = STEP_P1;
        3'd2:    stepSel = STEP_M1;
        3'd3:    stepSel = reqMode[0] ? STEP_P2 : STEP_NONE;
        3'd4:    stepSel = STEP_J;
        3'd5:    stepSel = STEP_K;
        default: stepSel = STEP_NONE;
      endcase
    end
  end

  always_comb begin
    st = '0;
    if (reqValid) begin
      st.capture = 1'b1;
      st.direct  = reqMode[1];
      st.ptrIdx  = ptrSel;
      st.step    = stepSel;
      st.stepEn  = (stepSel != STEP_NONE);
    end
  end
endmodule

// File: rtl/agu_dpath.sv
module agu_dpath
  import agu_pkg::*;
#(
  parameter int AW    = 16,
  parameter int BASEW = 11,
  parameter int REGW  = 4,
  localparam int DIRW = AW - BASEW
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         st,
  input  logic            wrEn,
  input  logic [3:0]      wrSel,
  input  logic [AW-1:0]   wrData,
  input  logic [DIRW-1:0] dirField,
  input  logic [REGW-1:0] dirReg,
  output logic [AW-1:0]   addrQ,
  output logic            validQ,
  output logic [REGW-1:0] moveQ
);
  logic [AW-1:0]    ptrQ [NPTR];
  logic [AW-1:0]    rbQ, reQ, jQ, kQ;
  logic [BASEW-1:0] baseQ;
  logic [AW-1:0]    curPtr, delta, sum, nextPtr;
  logic             wrapHit;

  assign curPtr = ptrQ[st.ptrIdx];

  always_comb begin
    unique case (st.step)
      STEP_P1: delta = AW'(1);
      STEP_M1: delta = '1;
      STEP_P2: delta = AW'(2);
      STEP_J:  delta = jQ;
      STEP_K:  delta = kQ;
      default: delta = '0;
    endcase
  end

  assign sum     = curPtr + delta;
  assign wrapHit = (rbQ != '0) && (curPtr == reQ) && (st.step != STEP_M1);
  assign nextPtr = wrapHit ? rbQ : sum;

  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    logic [AW-1:0] q;
    logic          wrHit, stepHit;
    assign wrHit   = wrEn && (wrSel == 4'(g));
    assign stepHit = st.capture && !st.direct && st.stepEn && (st.ptrIdx == PTRW'(g));
    always_ff @(posedge clk) begin
      if (!rstN)        q <= '0;
      else if (wrHit)   q <= wrData;
      else if (stepHit) q <= nextPtr;
    end
    assign ptrQ[g] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rbQ   <= '0;
      reQ   <= '0;
      jQ    <= '0;
      kQ    <= '0;
      baseQ <= '0;
    end else if (wrEn) begin
      case (wrSel)
        4'd4: rbQ   <= wrData;
        4'd5: reQ   <= wrData;
        4'd6: jQ    <= wrData;
        4'd7: kQ    <= wrData;
        4'd8: baseQ <= wrData[BASEW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      addrQ  <= '0;
      moveQ  <= '0;
    end else begin
      validQ <= st.capture;
      if (st.capture) begin
        addrQ <= st.direct ? {baseQ, dirField} : curPtr;
        moveQ <= st.direct ? dirReg : '0;
      end
    end
  end
endmodule

// File: rtl/agu_decode.sv
module agu_decode #(
  parameter int          AW       = 16,
  parameter int          NBANK    = 4,
  parameter logic [15:0] IOSEL    = 16'h4010,
  localparam int         BANKW    = 10,
  localparam int         BIDXW    = AW - BANKW,
  localparam int         ONCHIP   = NBANK << BANKW
) (
  input  logic [AW-1:0]    addr,
  input  logic             valid,
  output logic [NBANK-1:0] bankEn,
  output logic             eramHiEn,
  output logic             eramLoEn,
  output logic             ioEn,
  output logic             ioSelEn
);
  logic onChip, inIo;

  assign onChip = ({{(32-AW){1'b0}}, addr} < ONCHIP);
  assign inIo   = !onChip && (addr[AW-1:12] == 4'h4);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign bankEn[g] = valid && onChip && (addr[AW-1:BANKW] == BIDXW'(g));
  end

  assign ioEn     = valid && inIo;
  assign eramHiEn = valid && !onChip && !inIo && addr[AW-1];
  assign eramLoEn = valid && !onChip && !inIo && !addr[AW-1];
  assign ioSelEn  = valid && (addr == IOSEL);
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int          AW    = 16,
  parameter int          BASEW = 11,
  parameter int          NBANK = 4,
  parameter logic [15:0] IOSEL = 16'h4010,
  localparam int         DIRW  = AW - BASEW
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [3:0]       wrSel,
  input  logic [AW-1:0]    wrData,
  input  logic             reqValid,
  input  logic [1:0]       reqMode,
  input  logic [PTRW-1:0]  ptrSel,
  input  logic [2:0]       incSel,
  input  logic [DIRW-1:0]  dirField,
  input  logic [3:0]       dirReg,
  output logic             addrValid,
  output logic [AW-1:0]    addr,
  output logic [3:0]       moveReg,
  output logic [NBANK-1:0] bankEn,
  output logic             eramHiEn,
  output logic             eramLoEn,
  output logic             ioEn,
  output logic             ioSelEn
);
  strobe_t st;

  agu_ctrl ctrl_i (
    .reqValid(reqValid), .reqMode(reqMode), .ptrSel(ptrSel),
    .incSel(incSel), .st(st)
  );

  agu_dpath #(.AW(AW), .BASEW(BASEW), .REGW(4)) dpath_i (
    .clk(clk), .rstN(rstN), .st(st), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .dirField(dirField), .dirReg(dirReg),
    .addrQ(addr), .validQ(addrValid), .moveQ(moveReg)
  );

  agu_decode #(.AW(AW), .NBANK(NBANK), .IOSEL(IOSEL)) dec_i (
    .addr(addr), .valid(addrValid), .bankEn(bankEn),
    .eramHiEn(eramHiEn), .eramLoEn(eramLoEn), .ioEn(ioEn), .ioSelEn(ioSelEn)
  );
endmodule

// File: rtl/agu_chk.sv
module agu_chk #(
  parameter int          AW    = 16,
  parameter int          NBANK = 4,
  parameter int          DIRW  = 5,
  parameter logic [15:0] IOSEL = 16'h4010
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [1:0]       reqMode,
  input logic [DIRW-1:0]  dirField,
  input logic             addrValid,
  input logic [AW-1:0]    addr,
  input logic [NBANK-1:0] bankEn,
  input logic             eramHiEn,
  input logic             eramLoEn,
  input logic             ioEn,
  input logic             ioSelEn
);
  logic [NBANK+2:0] allEn;
  logic             lowAddr;
  assign allEn   = {bankEn, eramHiEn, eramLoEn, ioEn};
  assign lowAddr = ({{(32-AW){1'b0}}, addr} < (NBANK << 10));

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> addrValid);
  p_valid_drops_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !addrValid);
  p_direct_field_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqMode[1]) |=> (addr[DIRW-1:0] == $past(dirField)));
  p_one_enable_r10: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> ($countones(allEn) == 1));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    !addrValid |-> (allEn == '0) && !ioSelEn);
  p_bank_region_r9: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && lowAddr) |-> $onehot0(bankEn) && (bankEn != '0));
  p_iosel_r11: assert property (@(posedge clk) disable iff (!rstN)
    ioSelEn |-> ioEn && (addr == IOSEL));
endmodule

bind agu_top agu_chk #(.AW(AW), .NBANK(NBANK), .DIRW(DIRW), .IOSEL(IOSEL)) chk_i (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqMode(reqMode),
  .dirField(dirField), .addrValid(addrValid), .addr(addr), .bankEn(bankEn),
  .eramHiEn(eramHiEn), .eramLoEn(eramLoEn), .ioEn(ioEn), .ioSelEn(ioSelEn)
);

// File: tb/agu_tb_top.sv
module agu_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrSel = '0;
  logic [15:0] wrData = '0;
  logic        reqValid = 1'b0;
  logic [1:0]  reqMode = '0;
  logic [1:0]  ptrSel = '0;
  logic [2:0]  incSel = '0;
  logic [4:0]  dirField = '0;
  logic [3:0]  dirReg = '0;
  logic        addrValid;
  logic [15:0] addr;
  logic [3:0]  moveReg;
  logic [3:0]  bankEn;
  logic        eramHiEn, eramLoEn, ioEn, ioSelEn;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [15:0] mPtr [4];
  logic [15:0] mRb, mRe, mJ, mK;
  logic [10:0] mBase;

  agu_top dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .reqValid(reqValid), .reqMode(reqMode), .ptrSel(ptrSel), .incSel(incSel),
    .dirField(dirField), .dirReg(dirReg), .addrValid(addrValid), .addr(addr),
    .moveReg(moveReg), .bankEn(bankEn), .eramHiEn(eramHiEn), .eramLoEn(eramLoEn),
    .ioEn(ioEn), .ioSelEn(ioSelEn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] modelStep(input logic [15:0] p, input logic [1:0] md,
                                            input logic [2:0] inc);
    logic [15:0] d;
    d = '0;
    case (inc)
      3'd1: d = 16'd1;
      3'd2: d = 16'hFFFF;
      3'd3: if (md[0]) d = 16'd2; else return p;
      3'd4: d = mJ;
      3'd5: d = mK;
      default: return p;
    endcase
    if (mRb != 0 && p == mRe && inc != 3'd2) return mRb;
    return p + d;
  endfunction

  task automatic cycle(input logic rv, input logic [1:0] md, input logic [1:0] ps,
                       input logic [2:0] inc, input logic [4:0] fld, input logic [3:0] dr,
                       input logic we, input logic [3:0] ws, input logic [15:0] wd,
                       input string tag);
    logic [15:0] eAddr;
    logic [3:0]  eMove, eBank;
    logic        eHi, eLo, eIo, eSel, onChip, inIo;
    reqValid = rv; reqMode = md; ptrSel = ps; incSel = inc;
    dirField = fld; dirReg = dr; wrEn = we; wrSel = ws; wrData = wd;
    eAddr = md[1] ? {mBase, fld} : mPtr[ps];
    eMove = md[1] ? dr : 4'd0;
    if (rv && !md[1]) mPtr[ps] = modelStep(mPtr[ps], md, inc);
    if (we) begin
      case (ws)
        4'd0, 4'd1, 4'd2, 4'd3: mPtr[ws[1:0]] = wd;
        4'd4: mRb = wd;
        4'd5: mRe = wd;
        4'd6: mJ = wd;
        4'd7: mK = wd;
        4'd8: mBase = wd[10:0];
        default: ;
      endcase
    end
    onChip = eAddr < 16'h1000;
    inIo   = !onChip && eAddr[15:12] == 4'h4;
    eBank  = (rv && onChip) ? (4'b1 << eAddr[11:10]) : 4'b0;
    eIo    = rv && inIo;
    eHi    = rv && !onChip && !inIo && eAddr[15];
    eLo    = rv && !onChip && !inIo && !eAddr[15];
    eSel   = rv && eAddr == 16'h4010;
    @(posedge clk); #1;
    chk("R2 valid", int'(addrValid), int'(rv));
    if (rv) begin
      chk(tag, int'(addr), int'(eAddr));
      chk("R8 moveReg", int'(moveReg), int'(eMove));
    end
    chk("R9 bankEn", int'(bankEn), int'(eBank));
    chk("R10 segments", int'({eramHiEn, eramLoEn, ioEn}), int'({eHi, eLo, eIo}));
    chk("R11 ioSel", int'(ioSelEn), int'(eSel));
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] ws, input logic [15:0] wd);
    cycle(1'b0, 2'b00, 2'd0, 3'd0, 5'd0, 4'd0, 1'b1, ws, wd, "R12");
  endtask

  task automatic rq(input logic [1:0] md, input logic [1:0] ps, input logic [2:0] inc,
                    input string tag);
    cycle(1'b1, md, ps, inc, 5'd0, 4'd0, 1'b0, 4'd0, 16'd0, tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mPtr[i] = '0;
    mRb = '0; mRe = '0; mJ = '0; mK = '0; mBase = '0;
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 reset valid", int'(addrValid), 0);
    chk("R1 reset enables", int'({bankEn, eramHiEn, eramLoEn, ioEn, ioSelEn}), 0);
    for (int i = 0; i < 4; i++) rq(2'b00, 2'(i), 3'd0, "R1 pointer zero");
    rq(2'b00, 2'd0, 3'd4, "R1 J zero");
    rq(2'b00, 2'd0, 3'd5, "R1 K zero");
    rq(2'b00, 2'd0, 3'd0, "R1 after zero steps");
    cycle(1'b1, 2'b10, 2'd0, 3'd0, 5'd0, 4'd0, 1'b0, 4'd0, 16'd0, "R1 page zero");
    // R3 linear steps
    wr(4'd1, 16'h0100);
    rq(2'b00, 2'd1, 3'd1, "R3 +1");
    rq(2'b00, 2'd1, 3'd1, "R3 +1");
    rq(2'b00, 2'd1, 3'd2, "R3 -1");
    wr(4'd6, 16'hFFFC);
    rq(2'b00, 2'd1, 3'd4, "R3 J");
    wr(4'd7, 16'h0030);
    rq(2'b00, 2'd1, 3'd5, "R3 K");
    rq(2'b00, 2'd1, 3'd0, "R3 result");
    // R4 +2 only in compound mode
    rq(2'b00, 2'd1, 3'd3, "R4 plain +2");
    rq(2'b00, 2'd1, 3'd3, "R4 plain unchanged");
    rq(2'b01, 2'd1, 3'd3, "R4 compound +2");
    rq(2'b00, 2'd1, 3'd0, "R4 compound result");
    // R5 modulo wrap
    wr(4'd4, 16'h0020);
    wr(4'd5, 16'h0023);
    wr(4'd2, 16'h0022);
    rq(2'b00, 2'd2, 3'd1, "R5 before end");
    rq(2'b00, 2'd2, 3'd1, "R5 at end");
    rq(2'b00, 2'd2, 3'd0, "R5 wrapped to start");
    wr(4'd2, 16'h0023);
    rq(2'b00, 2'd2, 3'd2, "R5 -1 at end");
    rq(2'b00, 2'd2, 3'd0, "R5 -1 no wrap");
    wr(4'd2, 16'h0023);
    rq(2'b01, 2'd2, 3'd3, "R5 +2 at end");
    rq(2'b00, 2'd2, 3'd0, "R5 +2 wrapped");
    // R6 ring start zero gives linear steps
    wr(4'd4, 16'h0000);
    wr(4'd2, 16'h0023);
    rq(2'b00, 2'd2, 3'd1, "R6 at end");
    rq(2'b00, 2'd2, 3'd0, "R6 linear");
    // R7 R8 direct addressing
    wr(4'd8, 16'hF801);
    cycle(1'b1, 2'b10, 2'd2, 3'd1, 5'h1F, 4'hA, 1'b0, 4'd0, 16'd0, "R7 direct");
    rq(2'b00, 2'd2, 3'd0, "R7 pointer untouched");
    wr(4'd8, 16'h0200);
    cycle(1'b1, 2'b11, 2'd0, 3'd0, 5'h10, 4'h5, 1'b0, 4'd0, 16'd0, "R11 io select");
    cycle(1'b1, 2'b11, 2'd0, 3'd0, 5'h11, 4'h3, 1'b0, 4'd0, 16'd0, "R10 io other");
    // R12 write wins, bad select ignored
    cycle(1'b1, 2'b00, 2'd3, 3'd1, 5'd0, 4'd0, 1'b1, 4'd3, 16'h8888, "R12 collide");
    rq(2'b00, 2'd3, 3'd0, "R12 written kept");
    wr(4'd12, 16'h1234);
    for (int i = 0; i < 4; i++) rq(2'b00, 2'(i), 3'd0, "R12 ignored sel");
    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] wd;
      wd = ($urandom % 4 == 0) ? 16'($urandom) : 16'h0010 + 16'($urandom % 16);
      cycle(($urandom % 5) != 0, 2'($urandom), 2'($urandom), 3'($urandom),
            5'($urandom), 4'($urandom), ($urandom % 4) == 0, 4'($urandom % 10), wd,
            "R3 random address");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule